// File: doc/BRIEF.md
# Test-Register Move Decoder

This block watches an instruction byte stream and picks out the two-byte escape opcodes that move a value between a general-purpose register and one of the processor's test registers. Bytes arrive one at a time under a valid strobe. The sequence is an escape byte `0x0F`, then an opcode byte, then a ModR/M byte. Opcode `0x26` moves data into a test register and `0x24` moves data out of one. For every complete sequence the block raises a one-cycle done pulse. With that pulse it gives the direction, the test-register number and the general-purpose register number, together with at most one fault flag.

Legality is judged from three sideband inputs, sampled in the cycle the ModR/M byte is accepted: a protected-mode flag, the two-bit current privilege level, and an enable for the legacy opcodes. A legal move yields done with both fault flags low. An undefined form yields the invalid-opcode fault. A legal form issued from an unprivileged level in protected mode yields the protection fault. The execute stage uses the pulse to perform the move or to take the fault.

Top module: `trmov_decoder`

## Requirements
- R1: While reset is asserted, and after a reset that arrives in the middle of a sequence, the outputs are zero and the decoder is idle. A sequence that was cut short by reset gives no done pulse.
- R2: The bytes `0x0F`, `0x26`, ModR/M give `done`=1 exactly one clock after the ModR/M byte is accepted, with `dir_to_tr`=1, `tr_num`=ModR/M bits 5:3 and `gpr_num`=ModR/M bits 2:0. The fields are reported even when a fault is flagged.
- R3: The bytes `0x0F`, `0x24`, ModR/M give the same result with `dir_to_tr`=0.
- R4: A ModR/M byte whose bits 7:6 are not `2'b11` raises `fault_ud`.
- R5: A ModR/M byte whose bits 5:3 are 0, 1 or 2 raises `fault_ud`. Only test registers 3 to 7 exist.
- R6: When `legacy_en`=0, both opcodes raise `fault_ud`.
- R7: When `prot_mode`=1 and `cpl`≠0, an otherwise legal move raises `fault_gp`. With `prot_mode`=0 the move is legal at any `cpl`.
- R8: When both faults apply, only `fault_ud` is raised. The two fault flags are never high together.
- R9: An escape byte followed by any byte other than `0x24` or `0x26` returns the decoder to idle with no output. That second byte is discarded, and the byte after it is treated as a fresh instruction start.
- R10: `done` never lasts more than one cycle. While `done`=0, every output is zero, and a fault flag is only ever high together with `done`.
- R11: Cycles with `byte_valid`=0 are ignored whatever `byte_data` holds, so idle gaps may appear between the bytes of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | `byte_data` carries an instruction byte this cycle |
| byte_data | input | 8 | Instruction byte |
| prot_mode | input | 1 | 1 = protected mode, 0 = real-address mode |
| cpl | input | 2 | Current privilege level, 0 is most privileged |
| legacy_en | input | 1 | 1 = test-register opcodes are recognised |
| done | output | 1 | One-cycle pulse: a full sequence was decoded |
| dir_to_tr | output | 1 | 1 = general register to test register, 0 = the reverse |
| tr_num | output | 3 | Test-register number (ModR/M bits 5:3) |
| gpr_num | output | 3 | General-purpose register number (ModR/M bits 2:0) |
| fault_gp | output | 1 | General-protection fault for this sequence |
| fault_ud | output | 1 | Invalid-opcode fault for this sequence |

## Verification
The assertions assume that every input carries a known value whenever reset is released. They also assume that `cpl`, `prot_mode` and `legacy_en` are meaningful in the cycle a ModR/M byte is accepted, because several properties compare the registered result with `$past` of those inputs and of `byte_data`. The bench drives every input from a defined value at the falling edge, so no input changes near the sampling edge. It sets the sideband before each ModR/M byte and, during idle gaps, parks an escape code on `byte_data` with the strobe low.

// File: rtl/trmov_pkg.sv
package trmov_pkg;

   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned SEL_W   = 3;
   localparam int unsigned FORM_W  = 2;
   localparam int unsigned NUM_SEL = 1 << SEL_W;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ESC   = 2'd1,
      ST_MODRM = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic [FORM_W-1:0] form;
      logic [SEL_W-1:0]  sel;
      logic [SEL_W-1:0]  gpr;
   } modrm_t;

   typedef struct packed {
      logic             to_tr;
      logic [SEL_W-1:0] tr;
      logic [SEL_W-1:0] gpr;
      logic             gp;
      logic             ud;
   } result_t;

endpackage

// File: rtl/trmov_seq.sv
module trmov_seq
   import trmov_pkg::*;
#(
   parameter logic [BYTE_W-1:0] ESC_CODE = 8'h0F,
   parameter logic [BYTE_W-1:0] WR_CODE  = 8'h26,
   parameter logic [BYTE_W-1:0] RD_CODE  = 8'h24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              take_o,
   output logic              to_tr_o
);

   seq_state_e state_q;
   logic       to_tr_q;
   logic       is_wr;
   logic       is_rd;

   assign is_wr = (byte_data == WR_CODE);
   assign is_rd = (byte_data == RD_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         to_tr_q <= 1'b0;
      end else if (byte_valid) begin
         case (state_q)
            ST_IDLE: begin
               if (byte_data == ESC_CODE) state_q <= ST_ESC;
            end
            ST_ESC: begin
               if (is_wr) begin
                  state_q <= ST_MODRM;
                  to_tr_q <= 1'b1;
               end else if (is_rd) begin
                  state_q <= ST_MODRM;
                  to_tr_q <= 1'b0;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_MODRM: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign take_o  = byte_valid && (state_q == ST_MODRM);
   assign to_tr_o = to_tr_q;

   AST_ESC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ESC && byte_valid && !is_wr && !is_rd) |=> (state_q == ST_IDLE)); // R9

   AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> $stable(state_q)); // R11

endmodule

// File: rtl/trmov_legal.sv
module trmov_legal
   import trmov_pkg::*;
#(
   parameter int TR_FIRST   = 3,
   parameter int TR_LAST    = 7,
   parameter int CPL_W      = 2,
   parameter int PRIV_LEVEL = 0
) (
   input  logic [FORM_W-1:0] form_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              prot_mode,
   input  logic [CPL_W-1:0]  cpl,
   input  logic              legacy_en,
   output logic              ud_o,
   output logic              gp_o
);

   localparam logic [CPL_W-1:0]  PRIV_CODE = PRIV_LEVEL[CPL_W-1:0];
   localparam logic [FORM_W-1:0] REG_FORM  = '1;

   logic [NUM_SEL-1:0] tr_exists;
   logic               form_ok;

   if (TR_FIRST < 0 || TR_LAST >= NUM_SEL || TR_FIRST > TR_LAST) begin : g_bad_range
      $error("trmov_legal: test-register range outside the selector field");
   end
   if (CPL_W < 1 || PRIV_LEVEL < 0 || PRIV_LEVEL >= (1 << CPL_W)) begin : g_bad_priv
      $error("trmov_legal: privilege level does not fit the level width");
   end

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_tr_map
      assign tr_exists[i] = (i >= TR_FIRST) && (i <= TR_LAST);
   end

   assign form_ok = (form_i == REG_FORM);

   always_comb begin
      ud_o = !legacy_en || !form_ok || !tr_exists[sel_i];
      gp_o = !ud_o && prot_mode && (cpl != PRIV_CODE);
   end

endmodule

// File: rtl/trmov_result.sv
module trmov_result
   import trmov_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic               to_tr_i,
   input  logic [BYTE_W-1:0]  modrm_i,
   input  logic               ud_i,
   input  logic               gp_i,
   output logic               done_o,
   output result_t            res_o
);

   modrm_t  mr;
   result_t res_q;
   logic    done_q;

   assign mr = modrm_t'(modrm_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= take_i;
         if (take_i) begin
            res_q.to_tr <= to_tr_i;
            res_q.tr    <= mr.sel;
            res_q.gpr   <= mr.gpr;
            res_q.gp    <= gp_i;
            res_q.ud    <= ud_i;
         end else begin
            res_q <= '0;
         end
      end
   end

   assign done_o = done_q;
   assign res_o  = res_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R10

   AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_q.gp, res_q.ud})); // R8

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> (res_q == '0)); // R10

endmodule

// File: rtl/trmov_decoder.sv
module trmov_decoder
   import trmov_pkg::*;
#(
   parameter logic [7:0] ESC_CODE   = 8'h0F,
   parameter logic [7:0] WR_CODE    = 8'h26,
   parameter logic [7:0] RD_CODE    = 8'h24,
   parameter int         TR_FIRST   = 3,
   parameter int         TR_LAST    = 7,
   parameter int         CPL_W      = 2,
   parameter int         PRIV_LEVEL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic [7:0]       byte_data,
   input  logic             prot_mode,
   input  logic [CPL_W-1:0] cpl,
   input  logic             legacy_en,
   output logic             done,
   output logic             dir_to_tr,
   output logic [2:0]       tr_num,
   output logic [2:0]       gpr_num,
   output logic             fault_gp,
   output logic             fault_ud
);

   if (WR_CODE == RD_CODE || WR_CODE == ESC_CODE || RD_CODE == ESC_CODE) begin : g_bad_codes
      $error("trmov_decoder: escape and opcode values must all differ");
   end

   logic    take;
   logic    to_tr;
   logic    ud;
   logic    gp;
   modrm_t  mr_in;
   result_t res;

   assign mr_in = modrm_t'(byte_data);

   trmov_seq #(
      .ESC_CODE (ESC_CODE),
      .WR_CODE  (WR_CODE),
      .RD_CODE  (RD_CODE)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .take_o     (take),
      .to_tr_o    (to_tr)
   );

   trmov_legal #(
      .TR_FIRST   (TR_FIRST),
      .TR_LAST    (TR_LAST),
      .CPL_W      (CPL_W),
      .PRIV_LEVEL (PRIV_LEVEL)
   ) i_legal (
      .form_i    (mr_in.form),
      .sel_i     (mr_in.sel),
      .prot_mode (prot_mode),
      .cpl       (cpl),
      .legacy_en (legacy_en),
      .ud_o      (ud),
      .gp_o      (gp)
   );

   trmov_result i_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .to_tr_i (to_tr),
      .modrm_i (byte_data),
      .ud_i    (ud),
      .gp_i    (gp),
      .done_o  (done),
      .res_o   (res)
   );

   assign dir_to_tr = res.to_tr;
   assign tr_num    = res.tr;
   assign gpr_num   = res.gpr;
   assign fault_gp  = res.gp;
   assign fault_ud  = res.ud;

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(take)); // R2

   AST_REG_FORM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault_ud) |-> ($past(byte_data[7:6]) == 2'b11)); // R4

   AST_TR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault_ud) |-> (int'(tr_num) >= TR_FIRST && int'(tr_num) <= TR_LAST)); // R5

   AST_LEGACY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(legacy_en)) |-> fault_ud); // R6

   AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault_ud && !fault_gp) |-> (!$past(prot_mode) || $past(cpl) == CPL_W'(PRIV_LEVEL))); // R7

endmodule

// File: tb/test_trmov_decoder.sv
module test_trmov_decoder;

   localparam int unsigned HALF_NS = 10;
   localparam int          NV      = 15;

   // vector: {opcode[25:18], modrm[17:10], prot[9], cpl[8:7], legacy[6], exp_ud[5], exp_gp[4], req[3:0]}
   localparam logic [25:0] VECS [NV] = '{
      {8'h26, 8'hDA, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 legal, TR3 <- GPR2
      {8'h24, 8'hF8, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 legal, GPR0 <- TR7
      {8'h26, 8'hF7, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 real mode, any level
      {8'h24, 8'hE1, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 level 3
      {8'h26, 8'hEB, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 level 1
      {8'h24, 8'h30, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 form 00
      {8'h26, 8'hA2, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 form 10
      {8'h26, 8'h79, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 form 01
      {8'h24, 8'hC3, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 TR0
      {8'h26, 8'hD6, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 TR2
      {8'h24, 8'hEC, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 legacy off
      {8'h26, 8'hD8, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 level 2
      {8'h26, 8'h18, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 form fault beats level
      {8'h24, 8'hCD, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 legacy off beats level
      {8'h24, 8'hF5, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 4'd6}   // R6 legacy off, real mode
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       byte_valid;
   logic [7:0] byte_data;
   logic       prot_mode;
   logic [1:0] cpl;
   logic       legacy_en;
   logic       done;
   logic       dir_to_tr;
   logic [2:0] tr_num;
   logic [2:0] gpr_num;
   logic       fault_gp;
   logic       fault_ud;

   int total = 0;
   int bad   = 0;
   int pulses = 0;
   bit finished = 1'b0;

   always #(HALF_NS) clk = ~clk;

   trmov_decoder i_trmov_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .prot_mode  (prot_mode),
      .cpl        (cpl),
      .legacy_en  (legacy_en),
      .done       (done),
      .dir_to_tr  (dir_to_tr),
      .tr_num     (tr_num),
      .gpr_num    (gpr_num),
      .fault_gp   (fault_gp),
      .fault_ud   (fault_ud)
   );

   always @(negedge clk) if (rst_n && done) pulses++;

   task automatic put(input logic [7:0] b);
      byte_valid = 1'b1;
      byte_data  = b;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      byte_valid = 1'b0;
      byte_data  = 8'h0F;
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [10:0] outs();
      return {done, dir_to_tr, tr_num, gpr_num, fault_gp, fault_ud, 1'b0};
   endfunction

   function automatic logic [10:0] want(input logic [7:0] op, input logic [7:0] mr,
                                        input logic gp, input logic ud);
      return {1'b1, (op == 8'h26), mr[5:3], mr[2:0], gp, ud, 1'b0};
   endfunction

   initial begin
      rst_n = 1'b0;
      byte_valid = 1'b0;
      byte_data = 8'h00;
      prot_mode = 1'b1;
      cpl = 2'd0;
      legacy_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", outs(), 11'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         logic [25:0] v;
         v = VECS[k];
         prot_mode = v[9];
         cpl       = v[8:7];
         legacy_en = v[6];
         put(8'h0F);
         put(v[25:18]);
         put(v[17:10]);
         check($sformatf("R%0d vector %0d", v[3:0], k), outs(),
               want(v[25:18], v[17:10], v[4], v[5]));
         @(negedge clk);
         check($sformatf("R10 quiet after vector %0d", k), outs(), 11'd0);
      end

      prot_mode = 1'b1;
      cpl = 2'd0;
      legacy_en = 1'b1;

      // R9: escape then a foreign byte; the following bytes are not an instruction
      idle(1);
      begin
         int c0;
         c0 = pulses;
         put(8'h0F); put(8'h55); put(8'h26); put(8'hDA);
         idle(2);
         check("R9 abort then stray opcode", 11'(pulses), 11'(c0));
         c0 = pulses;
         put(8'h0F); put(8'h0F); put(8'h24); put(8'hF8);
         idle(2);
         check("R9 second escape discarded", 11'(pulses), 11'(c0));
      end
      put(8'h0F); put(8'h55); put(8'h0F); put(8'h26); put(8'hDA);
      check("R9 fresh start after abort", outs(), want(8'h26, 8'hDA, 1'b0, 1'b0));

      // R11: gaps inside a sequence, escape code parked on the data bus
      idle(2);
      put(8'h0F); idle(3); put(8'h24); idle(2); put(8'hF9);
      check("R11 gaps between bytes", outs(), want(8'h24, 8'hF9, 1'b0, 1'b0));

      // R1: reset in the middle of a sequence
      idle(2);
      begin
         int c0;
         c0 = pulses;
         put(8'h0F); put(8'h26);
         rst_n = 1'b0;
         @(negedge clk);
         check("R1 outputs during mid reset", outs(), 11'd0);
         rst_n = 1'b1;
         put(8'hDA);
         idle(2);
         check("R1 cut sequence gives no done", 11'(pulses), 11'(c0));
      end

      // R2 / R3: back-to-back instructions without gaps
      put(8'h0F); put(8'h26); put(8'hFF);
      check("R2 back-to-back first", outs(), want(8'h26, 8'hFF, 1'b0, 1'b0));
      put(8'h0F);
      check("R10 done lasts one cycle", outs(), 11'd0);
      put(8'h24); put(8'hE0);
      check("R3 back-to-back second", outs(), want(8'h24, 8'hE0, 1'b0, 1'b0));

      idle(2);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(2 * HALF_NS * 20000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule